// File: doc/BRIEF.md
# Shared-destination register file

This block is the operand store for a two-operand datapath in which an instruction's result replaces one of its own sources. It holds sixteen 16-bit registers and takes only two register addresses. The first address picks the register shown on read port A and is also the register that a write lands in. The second address picks the register shown on read port B and plays no part in writing.

Both reads are combinational, so the two ALU operands are available in the same cycle their addresses arrive, in the manner of LUT-based distributed RAM. A single write port stores the write data on the rising clock edge when the write enable is high. The source of that data is selected outside the block. The contents have no reset, so a register reads as unknown until it has been written.

Width, depth and the form of the read multiplexer are parameters. Elaboration-time checks reject depths that are not a power of two.

Top module: `shared_dst_regfile`

## Requirements
- R1: With default parameters the block holds 16 registers of 16 bits, addressed by 4-bit addresses 0 to 15. Every address selects its own register, with no aliasing between registers.
- R2: `rd_a` shows, combinationally and in the same cycle, the contents of the register selected by `addr_a`.
- R3: `rd_b` shows, combinationally and in the same cycle, the contents of the register selected by `addr_b`.
- R4: When `wr_en` is 1 at a rising edge of `clk`, `wr_data` is stored into the register selected by `addr_a`. Before that edge, `rd_a` shows the old value. After the edge it shows the new value.
- R5: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_data` and the addresses hold.
- R6: `addr_b` never selects the write target. A write with `addr_b` different from `addr_a` leaves the register at `addr_b` unchanged, as seen on `rd_b`.
- R7: When `addr_a` equals `addr_b`, `rd_a` and `rd_b` carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; a write takes effect on its rising edge |
| wr_en | input | 1 | Write enable, active high |
| addr_a | input | 4 | Selects the write target and the register on `rd_a` |
| addr_b | input | 4 | Selects the register on `rd_b` only |
| wr_data | input | 16 | Value stored on an enabled write |
| rd_a | output | 16 | Combinational read data for `addr_a` |
| rd_b | output | 16 | Combinational read data for `addr_b` |

## Verification
A stray row enable, or a write decoded from the wrong address, corrupts a register without showing anything at once. It shows only when some later read points at that register. The bench therefore re-reads all 256 address pairs after each write phase. Any damaged row then shows on both read ports within that sweep, a few hundred cycles at most.

A wrong read-port decode is different: it shows in the same cycle, as a value that differs from the one the bench expects for that address. The old-before-edge, new-after-edge behaviour is sampled around every write. A write that lands early, or one that is dropped, is seen one cycle after it was issued.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
   // Read-port multiplexer form
   typedef enum logic [0:0] {
      RD_INDEXED = 1'b0,   // plain indexed select
      RD_ONEHOT  = 1'b1    // one-hot decode feeding an AND-OR tree
   } srf_rd_style_e;

   function automatic bit srf_is_pow2(int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/srf_wr_decode.sv
`timescale 1ns/1ps
module srf_wr_decode #(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   output logic [NUM_REGS-1:0] wr_sel
);
   // One row enable per register, qualified by the write enable
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
      assign wr_sel[r] = wr_en && (wr_addr == ADDR_W'(r));
   end
endmodule

// File: rtl/srf_store.sv
`timescale 1ns/1ps
module srf_store #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_REGS = 16
) (
   input  logic                             clk,
   input  logic [NUM_REGS-1:0]              wr_sel,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);
   // Each row is its own enabled register; no reset on the contents
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
      logic [DATA_W-1:0] row_q;
      always_ff @(posedge clk) begin
         if (wr_sel[r]) row_q <= wr_data;
      end
      assign words[r] = row_q;
   end
endmodule

// File: rtl/srf_read_port.sv
`timescale 1ns/1ps
module srf_read_port #(
   parameter int unsigned          DATA_W   = 16,
   parameter int unsigned          NUM_REGS = 16,
   parameter int unsigned          ADDR_W   = 4,
   parameter srf_pkg::srf_rd_style_e STYLE  = srf_pkg::RD_ONEHOT
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
   input  logic [ADDR_W-1:0]               addr,
   output logic [DATA_W-1:0]               dout
);
   if (STYLE == srf_pkg::RD_INDEXED) begin : g_indexed
      assign dout = words[addr];
   end else begin : g_onehot
      logic [NUM_REGS-1:0] hit;
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
         assign hit[r] = (addr == ADDR_W'(r));
      end
      always_comb begin
         dout = '0;
         for (int r = 0; r < NUM_REGS; r++) begin
            dout = dout | (words[r] & {DATA_W{hit[r]}});
         end
      end
   end
endmodule

// File: rtl/shared_dst_regfile.sv
`timescale 1ns/1ps
module shared_dst_regfile #(
   parameter int unsigned            DATA_W   = 16,
   parameter int unsigned            NUM_REGS = 16,
   parameter srf_pkg::srf_rd_style_e RD_STYLE = srf_pkg::RD_ONEHOT,
   localparam int unsigned           ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);
   // Elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("shared_dst_regfile: DATA_W must be at least 1");
   end
   if (NUM_REGS < 2 || !srf_pkg::srf_is_pow2(NUM_REGS)) begin : g_bad_depth
      $error("shared_dst_regfile: NUM_REGS must be a power of two >= 2");
   end

   logic [NUM_REGS-1:0]             wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] words;

   // Address A is the only write address
   srf_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
      .wr_en  (wr_en),
      .wr_addr(addr_a),
      .wr_sel (wr_sel)
   );

   srf_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
      .clk    (clk),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .words  (words)
   );

   srf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
                   .STYLE(RD_STYLE)) u_rd_a (
      .words(words),
      .addr (addr_a),
      .dout (rd_a)
   );

   srf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
                   .STYLE(RD_STYLE)) u_rd_b (
      .words(words),
      .addr (addr_b),
      .dout (rd_b)
   );
endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
module srf_checker #(
   parameter int unsigned  DATA_W   = 16,
   parameter int unsigned  NUM_REGS = 16,
   localparam int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr_a,
   input logic [ADDR_W-1:0] addr_b,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_a,
   input logic [DATA_W-1:0] rd_b
);
   // Shadow copy and written flags; the block has no reset, so checks
   // apply only to rows written since time zero
   logic [DATA_W-1:0]   shadow [NUM_REGS];
   logic [NUM_REGS-1:0] seen  = '0;
   logic                armed = 1'b0;

   always_ff @(posedge clk) begin
      armed <= 1'b1;
      if (wr_en === 1'b1) begin
         shadow[addr_a] <= wr_data;
         seen[addr_a]   <= 1'b1;
      end
   end

   // R2: port A reflects the addressed row
   p_rd_a_match_r2: assert property (@(posedge clk) disable iff (!armed)
      seen[addr_a] |-> (rd_a == shadow[addr_a]));

   // R3: port B reflects the addressed row
   p_rd_b_match_r3: assert property (@(posedge clk) disable iff (!armed)
      seen[addr_b] |-> (rd_b == shadow[addr_b]));

   // R4: after an enabled write with A held, port A shows the written data
   p_write_lands_r4: assert property (@(posedge clk) disable iff (!armed)
      (wr_en === 1'b1) |=> (!$stable(addr_a) || rd_a == $past(wr_data)));

   // R5: with write disabled and A held, port A does not change
   p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
      (wr_en === 1'b0 && seen[addr_a]) |=> (!$stable(addr_a) || $stable(rd_a)));

   // R6: a write never disturbs the row on port B when B differs from A
   p_b_untouched_r6: assert property (@(posedge clk) disable iff (!armed)
      (wr_en === 1'b1 && addr_b != addr_a && seen[addr_b])
         |=> (!$stable(addr_b) || $stable(rd_b)));

   // R7: equal addresses give equal read data
   p_same_addr_r7: assert property (@(posedge clk) disable iff (!armed)
      (addr_a == addr_b && seen[addr_a]) |-> (rd_a == rd_b));
endmodule

bind shared_dst_regfile srf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk    (clk),
   .wr_en  (wr_en),
   .addr_a (addr_a),
   .addr_b (addr_b),
   .wr_data(wr_data),
   .rd_a   (rd_a),
   .rd_b   (rd_b)
);

// File: tb/sim_shared_dst_regfile.sv
`timescale 1ns/1ps
module sim_shared_dst_regfile;
   localparam int NREG = 16;

   logic        clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr_a = '0;
   logic [3:0]  addr_b = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_a;
   logic [15:0] rd_b;

   int n_chk  = 0;
   int n_fail = 0;

   logic [15:0]     exp_mem [NREG];
   logic [NREG-1:0] known = '0;

   always #10 clk = ~clk;   // 50 MHz

   shared_dst_regfile u0 (
      .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .addr_b(addr_b),
      .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (addr_a=%0d addr_b=%0d)",
                  req, act, exp, addr_a, addr_b);
      end
   endtask

   // One write cycle: sample before the edge (old value) and after it
   task automatic do_write(input int a, input int b, input logic [15:0] d,
                           input logic en, input string req_a);
      @(negedge clk);
      wr_en = en; addr_a = 4'(a); addr_b = 4'(b); wr_data = d;
      #5;
      if (known[a]) chk("R4 old value before edge", rd_a, exp_mem[a]);
      if (known[b]) chk("R6 port B before edge", rd_b, exp_mem[b]);
      @(posedge clk);
      #5;
      if (en) begin
         exp_mem[a] = d;
         known[a]   = 1'b1;
      end
      if (known[a]) chk(req_a, rd_a, exp_mem[a]);
      if (known[b]) chk((a == b) ? "R7 port B after own write" : "R6 port B after write",
                        rd_b, exp_mem[b]);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Read every address pair with writes disabled
   task automatic sweep_reads();
      for (int a = 0; a < NREG; a++) begin
         for (int b = 0; b < NREG; b++) begin
            @(negedge clk);
            wr_en = 1'b0; addr_a = 4'(a); addr_b = 4'(b);
            #5;
            chk((a == 0 || a == NREG - 1) ? "R1/R2 port A edge address" : "R2 port A read",
                rd_a, exp_mem[a]);
            chk("R3 port B read", rd_b, exp_mem[b]);
            if (a == b) chk("R7 equal addresses", rd_a, rd_b);
         end
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      // R4: first fill, distinct value per row, B points at another row
      for (int i = 0; i < NREG; i++)
         do_write(i, NREG - 1 - i, 16'(i * 16'h1357) ^ 16'hBEEF, 1'b1, "R4 first write");
      // R1: every row distinct, no aliasing
      sweep_reads();
      // R4: overwrite with inverted data, checking old then new around the edge
      for (int i = 0; i < NREG; i++)
         do_write(i, i, ~exp_mem[i], 1'b1, "R4 overwrite new value");
      // Extreme data patterns on the edge rows
      do_write(0, 15, 16'h0000, 1'b1, "R4 all-zero data");
      do_write(NREG - 1, 0, 16'hFFFF, 1'b1, "R4 all-ones data");
      sweep_reads();
      // R5: disabled writes with tempting data must change nothing
      for (int i = 0; i < NREG; i++)
         do_write(i, (i + 3) % NREG, ~exp_mem[i] ^ 16'h5A5A, 1'b0, "R5 disabled write held");
      sweep_reads();
      // R6: B addresses a different row during each write
      for (int i = 0; i < NREG; i++)
         do_write(i, (i + 5) % NREG, 16'(i * 16'h0F0F + 3), 1'b1, "R6 write via A only");
      sweep_reads();
      // Back-to-back writes to one row: each edge takes the newest data
      do_write(7, 7, 16'h1234, 1'b1, "R4 back-to-back first");
      do_write(7, 7, 16'hCAFE, 1'b1, "R4 back-to-back second");
      sweep_reads();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule